// File: doc/BRIEF.md
# Stereo Transmit Sample Buffer with Half-Pair Level Counting

This block stores outgoing audio samples between a register-write port and a serial audio transmitter. Software writes 32-bit words, and the block interprets each word according to one of four channel-packing modes. In the first mode each word holds a single sample and successive words alternate left then right. In two compact modes one word holds both samples. In the mono mode one word holds a sample that is played on both channels. Every entry in the buffer is a complete left/right pair. The transmitter takes one pair per frame through a valid/ready handshake.

Occupancy is reported in half-pair units, so one complete pair counts as two. A lone left sample that is still waiting for its right partner makes the level odd, and this shows a channel mismatch. A service request is raised while the level is below a programmable limit. A full flag tells writers when to stall. A write that arrives while the buffer is full is dropped and sets an overflow flag. The flag stays set until reset.

Top module: `tx_pair_fifo`

## Requirements
- R1: After reset the level is 0, and full, overflow and pop_valid are all low.
- R2: In mode 0 (dual) the first write after a completed pair is stored as the left sample and raises the level by 1, which makes it odd. The next write is stored as the right sample, completes the pair and raises the level by 1 again.
- R3: In mode 1 (compact 16) one write stores bits 15:0 as left and bits 31:16 as right, each zero-extended, and raises the level by 2.
- R4: In mode 2 (compact 8) one write stores bits 7:0 as left and bits 15:8 as right, each zero-extended. Bits 31:16 are ignored. The level rises by 2.
- R5: In mode 3 (mono) one write stores the word as both left and right and raises the level by 2.
- R6: Capacity is 16 level units (8 pairs). full is high exactly when the level is 16. A write while full is dropped: the level and the stored pairs are unchanged.
- R7: A write attempted while full sets overflow. Overflow then stays high until reset, even after the buffer drains.
- R8: svc_req is high exactly when the level is strictly below limit. A limit of 0 never requests, and a limit of 16 requests whenever space exists.
- R9: pop_valid is high only when the level is 2 or more. A pop (pop_valid and pop_ready both high) presents the oldest pair on pop_left/pop_right and lowers the level by 2. Pairs leave in write order.
- R10: A write in modes 1 to 3 while a dual-mode left sample is pending discards that left sample. The new pair takes its place, and the level becomes the even count of complete pairs plus 2.
- R11: A write and a pop in the same cycle both take effect, and the level changes by their net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Packing mode: 0 dual, 1 compact 16, 2 compact 8, 3 mono |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 32 | Written word |
| limit | input | 5 | Service-request threshold (even, 0 to 16) |
| level | output | 5 | Occupancy in half-pair units |
| full | output | 1 | Buffer holds 16 units |
| overflow | output | 1 | Sticky dropped-write flag |
| svc_req | output | 1 | Level below limit |
| pop_valid | output | 1 | A complete pair is available |
| pop_ready | input | 1 | Transmitter accepts the pair |
| pop_left | output | 32 | Left sample of the oldest pair |
| pop_right | output | 32 | Right sample of the oldest pair |

## Verification
The assertions check the following on every cycle: the level never exceeds 16, a pop is offered only when a whole pair is held, a refused write leaves the level alone, overflow stays set once raised, and each accepted write moves the level by exactly one unit in dual mode and to the next even value in the paired modes. Some behaviours can only be shown by the bench's scenarios. These are the bit packing of each mode, the order in which pairs leave, the fact that a dropped write never appears in the data stream, the discarding of an orphan left sample, and the limit comparisons at 0, 8 and 16.

// File: rtl/tx_pair_fifo.sv
module tx_pair_fifo #(
  parameter int SW    = 32,
  parameter int PAIRS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        mode,
  input  logic                              wr_en,
  input  logic [SW-1:0]                     wr_data,
  input  logic [$clog2(PAIRS+1):0]          limit,
  output logic [$clog2(PAIRS+1):0]          level,
  output logic                              full,
  output logic                              overflow,
  output logic                              svc_req,
  output logic                              pop_valid,
  input  logic                              pop_ready,
  output logic [SW-1:0]                     pop_left,
  output logic [SW-1:0]                     pop_right
);
  localparam int PW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int CW = $clog2(PAIRS + 1);
  localparam logic [1:0] M_DUAL = 2'd0, M_C16 = 2'd1, M_C8 = 2'd2, M_MONO = 2'd3;

  logic [SW-1:0] lmem [PAIRS];
  logic [SW-1:0] rmem [PAIRS];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] npairs;
  logic          half;
  logic [SW-1:0] pk_l, pk_r;

  assign level     = {npairs, half};
  assign full      = (npairs == CW'(PAIRS));
  assign pop_valid = (npairs != '0);
  assign svc_req   = (level < limit);
  assign pop_left  = lmem[rptr];
  assign pop_right = rmem[rptr];

  wire pop_fire  = pop_valid && pop_ready;
  wire wr_ok     = wr_en && !full;
  wire left_only = wr_ok && (mode == M_DUAL) && !half;
  wire pair_done = wr_ok && !left_only;

  always_comb begin
    pk_l = wr_data;
    pk_r = wr_data;
    case (mode)
      M_C16: begin pk_l = SW'(wr_data[15:0]); pk_r = SW'(wr_data[31:16]); end
      M_C8:  begin pk_l = SW'(wr_data[7:0]);  pk_r = SW'(wr_data[15:8]);  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (left_only) lmem[wptr] <= wr_data;
    else if (pair_done) begin
      if (mode != M_DUAL) lmem[wptr] <= pk_l;
      rmem[wptr] <= pk_r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      npairs   <= '0;
      half     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (left_only) half <= 1'b1;
      else if (pair_done) half <= 1'b0;
      if (pair_done) wptr <= (wptr == PW'(PAIRS - 1)) ? '0 : wptr + 1'b1;
      if (pop_fire)  rptr <= (rptr == PW'(PAIRS - 1)) ? '0 : rptr + 1'b1;
      npairs   <= npairs + CW'(pair_done) - CW'(pop_fire);
      overflow <= overflow | (wr_en && full);
    end
  end

  p_level_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (CW+1)'(2*PAIRS));

  p_pop_whole_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> level >= 2);

  p_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !pop_ready) |=> level == $past(level));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_dual_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && mode == M_DUAL && !pop_fire) |=> level == $past(level) + 1'b1);

  p_pair_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && mode != M_DUAL && !pop_fire) |=>
      level == ($past(level) & ~(CW+1)'(1)) + (CW+1)'(2));
endmodule

// File: tb/tx_pair_fifo_test.sv
module tx_pair_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4:0]  limit = '0;
  logic [4:0]  level;
  logic        full, overflow, svc_req, pop_valid;
  logic        pop_ready = 1'b0;
  logic [31:0] pop_left, pop_right;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  tx_pair_fifo uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .limit(limit), .level(level), .full(full), .overflow(overflow),
    .svc_req(svc_req), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_left(pop_left), .pop_right(pop_right)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      miscompares++;
      $display("FAIL watchdog: act %0d cycles exp under 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // {mode, data, exp_left, exp_right}
  localparam logic [97:0] VEC [6] = '{
    {2'd1, 32'h1234_5678, 32'h0000_5678, 32'h0000_1234},
    {2'd2, 32'hFFFF_A55A, 32'h0000_005A, 32'h0000_00A5},
    {2'd3, 32'hCAFE_BABE, 32'hCAFE_BABE, 32'hCAFE_BABE},
    {2'd0, 32'h0BAD_F00D, 32'h0BAD_F00D, 32'hF452_0FF2},
    {2'd2, 32'h0000_0180, 32'h0000_0080, 32'h0000_0001},
    {2'd1, 32'h8000_0001, 32'h0000_0001, 32'h0000_8000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [31:0] d);
    @(negedge clk);
    mode = m; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [31:0] el, input logic [31:0] er);
    @(negedge clk);
    chk({tag, " pop_valid"}, 32'(pop_valid), 32'd1);
    chk({tag, " left"}, pop_left, el);
    chk({tag, " right"}, pop_right, er);
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level", 32'(level), 0);
    chk("R1 full", 32'(full), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 pop_valid", 32'(pop_valid), 0);
    limit = 5'd0;  #1 chk("R8 limit0", 32'(svc_req), 0);
    limit = 5'd16; #1 chk("R8 limit16 empty", 32'(svc_req), 1);

    foreach (VEC[i]) begin
      if (VEC[i][97:96] == 2'd0) begin
        wr(2'd0, VEC[i][95:64]);
        chk("R2 odd level", 32'(level), 1);
        chk("R9 no pop on half", 32'(pop_valid), 0);
        wr(2'd0, ~VEC[i][95:64]);
      end else begin
        wr(VEC[i][97:96], VEC[i][95:64]);
      end
      chk("R3 R4 R5 level", 32'(level), 2);
      pop_chk("R2 R3 R4 R5 data", VEC[i][63:32], VEC[i][31:0]);
      chk("R9 level after pop", 32'(level), 0);
    end

    limit = 5'd8;
    for (int k = 0; k < 8; k++) begin
      wr(2'd3, 32'h100 + 32'(k));
      if (k == 2) chk("R8 level6 lim8", 32'(svc_req), 1);
      if (k == 3) chk("R8 level8 lim8", 32'(svc_req), 0);
    end
    chk("R6 level full", 32'(level), 16);
    chk("R6 full", 32'(full), 1);
    limit = 5'd16; #1 chk("R8 limit16 full", 32'(svc_req), 0);
    chk("R7 no ovf yet", 32'(overflow), 0);
    wr(2'd3, 32'hDEAD_DEAD);
    chk("R6 level held", 32'(level), 16);
    chk("R7 overflow set", 32'(overflow), 1);
    for (int k = 0; k < 8; k++)
      pop_chk("R6 R9 order", 32'h100 + 32'(k), 32'h100 + 32'(k));
    chk("R6 drained", 32'(level), 0);
    chk("R7 overflow sticky", 32'(overflow), 1);

    wr(2'd0, 32'h0000_AAAA);
    chk("R10 odd", 32'(level), 1);
    wr(2'd1, 32'h2222_1111);
    chk("R10 level", 32'(level), 2);
    pop_chk("R10 data", 32'h0000_1111, 32'h0000_2222);
    chk("R10 empty", 32'(level), 0);

    wr(2'd3, 32'h0000_0055);
    @(negedge clk);
    mode = 2'd3; wr_data = 32'h0000_0066; wr_en = 1'b1; pop_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pop_ready = 1'b0;
    chk("R11 net level", 32'(level), 2);
    pop_chk("R11 data", 32'h0000_0066, 32'h0000_0066);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ovf cleared", 32'(overflow), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule